// File: doc/BRIEF.md
# Glitch-Free Internal Clock Selector

This block produces the system clock from two free-running oscillator inputs. The fast input feeds a power-of-two postscaler with ten taps, from divide-by-1 down to divide-by-512. The slow input is routed to the output on its own. A 4-bit select code picks one of eleven sources. Several codes map to the same rate, so software can choose a code without forcing an oscillator change.

When a new code is written, a controller running on the fast input performs the switchover as a handshake. If the target oscillator is stopped, a modelled start-up delay runs first. The gate of the old source is then closed on a falling edge of that source. The output stays low until the gate of the new source opens on the next low phase of the new source. After that, the status bits are updated.

Every gate request crosses into its source domain through two flops. Every gate state crosses back to the controller through two flops. A write that arrives during a switch is held and carried out once the current switch is done.

Top module: `intClkSelect`

## Requirements
- R1: After reset the select code reads 0111, the fast-oscillator active bit is 1, the slow-oscillator active and slow-ready bits are 0, and the output settles to the fast input divided by 32.
- R2: Select codes map to fast-input divisors as follows. 1111 gives /1, 1110 gives /2, 1101 gives /4, 1100 gives /8 and 1011 gives /16. 1010 and 0111 give /32. 1001 and 0110 give /64. 1000 and 0101 give /128. 0100 gives /256. 0011, 0010 and 0001 give /512.
- R3: Select code 0000 routes the slow oscillator input to the output.
- R4: The output never carries a high or low pulse shorter than half a fast-input period. At most one source gate is requested at any time, and the old gate is seen closed before the new gate is requested.
- R5: When the target oscillator is stopped, its active bit rises at the start of the switch. The switch lasts at least the start-up count of that oscillator (HF_START_CYC or LF_START_CYC fast-input cycles). For the slow oscillator, the slow-ready bit rises only after that count.
- R6: A switch between two codes served by the same running oscillator inserts no start-up delay. A switch between /1 and /2 finishes in fewer than HF_START_CYC cycles. A duplicate code for the tap already in use finishes within 5 cycles, and the output period does not change.
- R7: When a switch completes onto the slow oscillator, the fast active bit is 0 and the slow active and slow-ready bits are 1. When it completes onto a postscaler tap, the fast active bit is 1 and both slow bits are 0.
- R8: The switch-busy bit is 1 in the cycle after any write. It stays 1 until the status update is done, and it is 0 once no switch is running or pending.
- R9: A write accepted during a switch is latched and carried out after the current switch. If several writes arrive, the last one wins.
- R10: The select-code output shows the code whose source is driving the clock, and it changes only when a switch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hfClk | input | 1 | Fast free-running oscillator; also clocks the controller |
| lfClk | input | 1 | Slow free-running oscillator |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Select-code write strobe, sampled on hfClk |
| wrCode | input | 4 | Select code to write |
| sysClk | output | 1 | Glitch-free selected system clock |
| selCode | output | 4 | Select code currently driving sysClk |
| hfActive | output | 1 | Fast oscillator enabled |
| lfActive | output | 1 | Slow oscillator enabled |
| lfReady | output | 1 | Slow oscillator past its start-up count |
| switchBusy | output | 1 | Switch running or pending |

## Verification
The assertions assume that wrEn and wrCode are stable around rising edges of hfClk. They also assume that both oscillator inputs keep toggling, so that every gate handshake can finish. The bench drives writes only on falling edges of hfClk and runs the slow input at a fixed period throughout. Some writes are issued back to back while a switch is running, to exercise the pending path. Every such write still meets the fast-clock sampling window.

// File: rtl/intClkSel_pkg.sv
`timescale 1ns/1ps
package intClkSel_pkg;
  localparam int TAP_CNT = 10;
  localparam int SRC_CNT = TAP_CNT + 1;
  localparam int LF_SRC  = TAP_CNT;
  localparam int SRC_W   = $clog2(SRC_CNT);
  localparam int CODE_W  = 4;
  localparam logic [CODE_W-1:0] RESET_CODE = 4'b0111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DROP, ST_RAISE, ST_DONE
  } swState_t;

  typedef struct packed {
    logic [SRC_CNT-1:0] gateReq;
  } ctlStrobe_t;

  typedef struct packed {
    logic [SRC_CNT-1:0] gateAck;
  } dpStatus_t;

  // Code to source index: 0..9 postscaler taps, 10 slow oscillator.
  function automatic logic [SRC_W-1:0] codeToSrc(input logic [CODE_W-1:0] code);
    logic [SRC_W-1:0] idx;
    if (code[3])          idx = SRC_W'(4'd15 - code);
    else if (code == '0)  idx = SRC_W'(LF_SRC);
    else if (code <= 4'd3) idx = SRC_W'(TAP_CNT - 1);
    else                  idx = SRC_W'(4'd12 - code);
    return idx;
  endfunction
endpackage

// File: rtl/clkGateCell.sv
`timescale 1ns/1ps
module clkGateCell (
  input  logic srcClk,
  input  logic rstN,
  input  logic enReq,
  output logic gateOn,
  output logic gatedClk
);
  logic syncA, syncB;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= enReq;
      syncB <= syncA;
    end
  end

  // Gate changes only while the source is low.
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) gateOn <= 1'b0;
    else       gateOn <= syncB;
  end

  assign gatedClk = srcClk & gateOn;
endmodule

// File: rtl/clkDatapath.sv
`timescale 1ns/1ps
module clkDatapath
  import intClkSel_pkg::*;
(
  input  logic       hfClk,
  input  logic       lfClk,
  input  logic       rstN,
  input  ctlStrobe_t ctlStb,
  output dpStatus_t  dpStat,
  output logic       sysClk
);
  localparam int DIV_W = TAP_CNT - 1;

  logic [DIV_W-1:0]   divCnt;
  logic [SRC_CNT-1:0] srcClk;
  logic [SRC_CNT-1:0] gateLive;
  logic [SRC_CNT-1:0] gatedOut;
  logic [SRC_CNT-1:0] ackS1, ackS2;

  always_ff @(posedge hfClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign srcClk[0]      = hfClk;
  assign srcClk[LF_SRC] = lfClk;

  for (genvar k = 1; k < TAP_CNT; k++) begin : g_tap
    assign srcClk[k] = divCnt[k-1];
  end

  for (genvar s = 0; s < SRC_CNT; s++) begin : g_gate
    clkGateCell u_cell (
      .srcClk  (srcClk[s]),
      .rstN    (rstN),
      .enReq   (ctlStb.gateReq[s]),
      .gateOn  (gateLive[s]),
      .gatedClk(gatedOut[s])
    );
  end

  always_ff @(posedge hfClk or negedge rstN) begin
    if (!rstN) begin
      ackS1 <= '0;
      ackS2 <= '0;
    end else begin
      ackS1 <= gateLive;
      ackS2 <= ackS1;
    end
  end

  assign dpStat.gateAck = ackS2;
  assign sysClk = |gatedOut;
endmodule

// File: rtl/clkSwitchCtl.sv
`timescale 1ns/1ps
module clkSwitchCtl
  import intClkSel_pkg::*;
#(
  parameter int HF_START_CYC = 16,
  parameter int LF_START_CYC = 64
) (
  input  logic              ctlClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrCode,
  input  dpStatus_t         dpStat,
  output ctlStrobe_t        ctlStb,
  output logic [CODE_W-1:0] selCode,
  output logic              hfActive,
  output logic              lfActive,
  output logic              lfReady,
  output logic              switchBusy
);
  localparam int MAX_START = (HF_START_CYC > LF_START_CYC) ? HF_START_CYC : LF_START_CYC;
  localparam int CNT_W     = $clog2(MAX_START + 1);
  localparam logic [SRC_W-1:0] RESET_SRC = codeToSrc(RESET_CODE);

  swState_t           state;
  logic [SRC_W-1:0]   curSrc, nxtSrc, newSrc;
  logic [CODE_W-1:0]  pendCode, tgtCode, curCode;
  logic               pendValid;
  logic               hfOn, lfOn, lfRdy;
  logic [CNT_W-1:0]   startCnt, startLim;
  logic [SRC_CNT-1:0] gateReq;
  logic               newIsLf, nxtIsLf;

  assign newSrc   = codeToSrc(pendCode);
  assign newIsLf  = (newSrc == SRC_W'(LF_SRC));
  assign nxtIsLf  = (nxtSrc == SRC_W'(LF_SRC));
  assign startLim = nxtIsLf ? CNT_W'(LF_START_CYC - 1) : CNT_W'(HF_START_CYC - 1);

  // Pending write latch: newest write wins, consumed when idle.
  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendCode  <= RESET_CODE;
    end else if (wrEn) begin
      pendValid <= 1'b1;
      pendCode  <= wrCode;
    end else if (state == ST_IDLE) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RAISE;
      curSrc   <= RESET_SRC;
      nxtSrc   <= RESET_SRC;
      tgtCode  <= RESET_CODE;
      curCode  <= RESET_CODE;
      hfOn     <= 1'b1;
      lfOn     <= 1'b0;
      lfRdy    <= 1'b0;
      startCnt <= '0;
      gateReq  <= SRC_CNT'(1) << RESET_SRC;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pendValid) begin
            tgtCode <= pendCode;
            nxtSrc  <= newSrc;
            if (newSrc == curSrc) begin
              state <= ST_DONE;
            end else if (newIsLf ? lfOn : hfOn) begin
              gateReq <= '0;
              state   <= ST_DROP;
            end else begin
              startCnt <= '0;
              if (newIsLf) lfOn <= 1'b1;
              else         hfOn <= 1'b1;
              state <= ST_START;
            end
          end
        end
        ST_START: begin
          if (startCnt == startLim) begin
            if (nxtIsLf) lfRdy <= 1'b1;
            gateReq <= '0;
            state   <= ST_DROP;
          end else begin
            startCnt <= startCnt + 1'b1;
          end
        end
        ST_DROP: begin
          if (!dpStat.gateAck[curSrc]) begin
            gateReq[nxtSrc] <= 1'b1;
            state <= ST_RAISE;
          end
        end
        ST_RAISE: begin
          if (dpStat.gateAck[nxtSrc]) state <= ST_DONE;
        end
        ST_DONE: begin
          curSrc  <= nxtSrc;
          curCode <= tgtCode;
          if (nxtIsLf) begin
            hfOn <= 1'b0;
          end else begin
            lfOn  <= 1'b0;
            lfRdy <= 1'b0;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ctlStb.gateReq = gateReq;
  assign selCode    = curCode;
  assign hfActive   = hfOn;
  assign lfActive   = lfOn;
  assign lfReady    = lfRdy;
  assign switchBusy = (state != ST_IDLE) || pendValid;
endmodule

// File: rtl/intClkSelect.sv
`timescale 1ns/1ps
module intClkSelect
  import intClkSel_pkg::*;
#(
  parameter int HF_START_CYC = 16,
  parameter int LF_START_CYC = 64
) (
  input  logic              hfClk,
  input  logic              lfClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrCode,
  output logic              sysClk,
  output logic [CODE_W-1:0] selCode,
  output logic              hfActive,
  output logic              lfActive,
  output logic              lfReady,
  output logic              switchBusy
);
  ctlStrobe_t ctlStb;
  dpStatus_t  dpStat;

  clkSwitchCtl #(
    .HF_START_CYC(HF_START_CYC),
    .LF_START_CYC(LF_START_CYC)
  ) u_ctl (
    .ctlClk    (hfClk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrCode    (wrCode),
    .dpStat    (dpStat),
    .ctlStb    (ctlStb),
    .selCode   (selCode),
    .hfActive  (hfActive),
    .lfActive  (lfActive),
    .lfReady   (lfReady),
    .switchBusy(switchBusy)
  );

  clkDatapath u_dp (
    .hfClk (hfClk),
    .lfClk (lfClk),
    .rstN  (rstN),
    .ctlStb(ctlStb),
    .dpStat(dpStat),
    .sysClk(sysClk)
  );
endmodule

// File: rtl/intClkSelect_chk.sv
`timescale 1ns/1ps
module intClkSelect_chk
  import intClkSel_pkg::*;
(
  input logic               hfClk,
  input logic               rstN,
  input logic               wrEn,
  input logic               switchBusy,
  input logic [CODE_W-1:0]  selCode,
  input logic               hfActive,
  input logic               lfActive,
  input logic               lfReady,
  input logic [SRC_CNT-1:0] gateReq,
  input logic [SRC_CNT-1:0] gateAck
);
  // R4
  req_onehot_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    $onehot0(gateReq));

  // R4
  ack_onehot_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    $onehot0(gateAck));

  // R4
  idle_one_gate_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    !switchBusy |-> ($countones(gateAck) == 1 && gateReq == gateAck));

  // R8
  busy_after_write_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    wrEn |=> switchBusy);

  // R10
  selcode_hold_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    (!switchBusy && !wrEn) |=> $stable(selCode));

  // R5
  ready_needs_active_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    lfReady |-> lfActive);

  // R7
  some_osc_on_chk: assert property (@(posedge hfClk) disable iff (!rstN)
    !switchBusy |-> (hfActive != lfActive));
endmodule

bind intClkSelect intClkSelect_chk u_chk (
  .hfClk     (hfClk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .switchBusy(switchBusy),
  .selCode   (selCode),
  .hfActive  (hfActive),
  .lfActive  (lfActive),
  .lfReady   (lfReady),
  .gateReq   (ctlStb.gateReq),
  .gateAck   (dpStat.gateAck)
);

// File: tb/tb_intClkSelect.sv
`timescale 1ns/1ps
module tb_intClkSelect;
  localparam int HF_ST = 40;
  localparam int LF_ST = 120;
  localparam real HF_PER = 8.0;
  localparam real LF_PER = 50.0;

  logic hfClk = 0, lfClk = 0, rstN = 0, wrEn = 0;
  logic [3:0] wrCode = 0;
  logic sysClk, hfActive, lfActive, lfReady, switchBusy;
  logic [3:0] selCode;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  realtime tRise, tFall, minHigh = 1.0e9, minLow = 1.0e9;
  bit sawRise = 0, sawFall = 0;

  intClkSelect #(.HF_START_CYC(HF_ST), .LF_START_CYC(LF_ST)) dut (
    .hfClk(hfClk), .lfClk(lfClk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode),
    .sysClk(sysClk), .selCode(selCode), .hfActive(hfActive), .lfActive(lfActive),
    .lfReady(lfReady), .switchBusy(switchBusy)
  );

  always #(HF_PER/2) hfClk = ~hfClk;
  always #(LF_PER/2) lfClk = ~lfClk;

  always @(posedge sysClk) begin
    if (sawFall && ($realtime - tFall) < minLow) minLow = $realtime - tFall;
    tRise = $realtime; sawRise = 1;
  end
  always @(negedge sysClk) begin
    if (sawRise && ($realtime - tRise) < minHigh) minHigh = $realtime - tRise;
    tFall = $realtime; sawFall = 1;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge hfClk) begin
    cyc++;
    if (cyc >= 190000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      summary();
    end
  end

  task automatic chk(string req, bit ok, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int srcOf(int code);
    if (code >= 8) return 15 - code;
    if (code == 0) return 10;
    if (code <= 3) return 9;
    return 12 - code;
  endfunction

  function automatic longint expPerPs(int code);
    int s = srcOf(code);
    if (s == 10) return longint'(LF_PER * 1000.0);
    return longint'(HF_PER * 1000.0) * (longint'(1) << s);
  endfunction

  task automatic writeCode(int code);
    @(negedge hfClk); wrEn = 1; wrCode = 4'(code);
    @(negedge hfClk); wrEn = 0;
  endtask

  task automatic waitIdle(output int n);
    n = 1;
    while (switchBusy && n < 6000) begin
      @(negedge hfClk); n++;
    end
  endtask

  task automatic measure(output longint perPs);
    realtime t0;
    @(posedge sysClk); @(posedge sysClk);
    t0 = $realtime;
    @(posedge sysClk); @(posedge sysClk);
    perPs = longint'(($realtime - t0) * 500.0);
    @(negedge hfClk);
  endtask

  task automatic doSwitch(int code, int prev, string rq);
    int n; longint p; longint ep;
    writeCode(code);
    chk("R8 busy after write", switchBusy == 1, switchBusy, 1);
    waitIdle(n);
    chk("R8 busy clears", switchBusy == 0, switchBusy, 0);
    chk("R10 selCode", selCode == 4'(code), selCode, code);
    if (code == 0) begin
      chk("R7 lf status", {hfActive, lfActive, lfReady} == 3'b011, {hfActive, lfActive, lfReady}, 3'b011);
    end else begin
      chk("R7 hf status", {hfActive, lfActive, lfReady} == 3'b100, {hfActive, lfActive, lfReady}, 3'b100);
    end
    if (prev >= 0 && srcOf(prev) != 10 && code == 0)
      chk("R5 lf startup length", n >= LF_ST, n, LF_ST);
    if (prev == 0 && code != 0)
      chk("R5 hf startup length", n >= HF_ST, n, HF_ST);
    if ((prev == 15 && code == 14) || (prev == 14 && code == 15))
      chk("R6 same source no delay", n < HF_ST, n, HF_ST);
    measure(p);
    ep = expPerPs(code);
    chk(rq, p == ep, p, ep);
  endtask

  initial begin
    int n; longint p;
    repeat (3) @(negedge hfClk);
    rstN = 1;
    @(negedge hfClk);
    // R1 reset state
    chk("R1 reset code", selCode == 4'b0111, selCode, 7);
    chk("R1 reset status", {hfActive, lfActive, lfReady} == 3'b100, {hfActive, lfActive, lfReady}, 3'b100);
    waitIdle(n);
    chk("R8 idle after reset", switchBusy == 0, switchBusy, 0);
    measure(p);
    chk("R1 reset period", p == 256000, p, 256000);

    // R2 R3 sweep down then up through every code
    for (int c = 15; c >= 0; c--) doSwitch(c, (c == 15) ? 7 : c + 1, (c == 0) ? "R3 lf period" : "R2 period");
    for (int c = 1; c <= 15; c++) doSwitch(c, c - 1, "R2 period");

    // R5 lf ready rises only after startup count
    begin
      int k = 0;
      writeCode(0);
      while (!lfActive && k < 100) begin @(negedge hfClk); k++; end
      chk("R5 lf active early, not ready", lfActive && !lfReady, lfReady, 0);
      k = 0;
      while (!lfReady && k < 1000) begin @(negedge hfClk); k++; end
      chk("R5 ready after count", k >= LF_ST - 2, k, LF_ST - 2);
      waitIdle(n);
    end

    // R6 duplicate code for the same tap
    doSwitch(10, 0, "R2 period");
    writeCode(7);
    waitIdle(n);
    chk("R6 duplicate quick", n <= 5, n, 5);
    chk("R10 duplicate code", selCode == 4'b0111, selCode, 7);
    measure(p);
    chk("R6 period unchanged", p == 256000, p, 256000);

    // R9 pending writes: last wins
    writeCode(15);
    writeCode(4);
    waitIdle(n);
    chk("R9 pending applied", selCode == 4'b0100, selCode, 4);
    measure(p);
    chk("R9 pending period", p == expPerPs(4), p, expPerPs(4));
    writeCode(12);
    writeCode(13);
    writeCode(0);
    waitIdle(n);
    chk("R9 last write wins", selCode == 4'b0000, selCode, 0);
    chk("R9 lf status", lfActive && lfReady && !hfActive, {hfActive, lfActive, lfReady}, 3'b011);
    measure(p);
    chk("R9 lf period", p == expPerPs(0), p, expPerPs(0));

    // R4 no runt pulses
    chk("R4 min high", longint'(minHigh * 1000.0) >= 4000, longint'(minHigh * 1000.0), 4000);
    chk("R4 min low", longint'(minLow * 1000.0) >= 4000, longint'(minLow * 1000.0), 4000);
    summary();
  end
endmodule